// File: doc/BRIEF.md
# Greyscale Frame-Rate-Control Dither Engine

This block turns a 4-bit grey level into the single on/off bit that a one-bit-per-dot panel needs. It gets intermediate shades by switching each dot on for a fixed fraction of frames. Neighbouring lines and columns are offset in phase so that the flicker spreads over space as well as time. The fractions are stored as programmable patterns. Each pattern is made of 4-bit rows, and it has as many rows as its fraction has in the denominator (3, 4, 5 or 7).

Per pixel, the pattern row is chosen by (frame index + line index) modulo the denominator. The bit inside that row is chosen by the column modulo 4. The dot output is combinational from the pixel inputs and the active pattern registers.

Software-side writes land in a pending copy. The pending copy moves into the active copy only on a frame boundary pulse, so a frame is never drawn with two different patterns. A restore input reloads the pending copy with the built-in defaults.

Top module: `frc_dither`

## Requirements
- R1: After synchronous reset, the active and pending patterns both hold the defaults. Written as hex, with row 0 in the most significant used nibble and bit 3 of a row belonging to column 0 mod 4, the defaults are:
  - 2/3 = 7DA
  - 2/4 = A5A5
  - 3/4 = 7DBE
  - 3/5 = 7A5AD
  - 4/5 = 7DFBE
  - 4/7 = B9DC663
  - 5/7 = 7B5ADEF
  - 6/7 = FBFDFE7
- R2: Grey 15 always gives dot_o=1 and grey 0 always gives dot_o=0, whatever the position and pattern state.
- R3: Grey codes select stored patterns as follows: 14→6/7, 13→4/5, 12→3/4, 11→5/7, 10→2/3, 9→3/5, 8→4/7, 7→2/4.
- R4: The active row is (frame_idx + line_idx) mod D, where D is the pattern's row count. Row r sits at bits [4(D-1-r)+3 : 4(D-1-r)].
- R5: Within the row, the output bit is bit (3 − pix_col mod 4).
- R6: Codes without a pattern of their own use the bitwise inverse of the complementary pattern: 6→~4/7, 5→~3/5, 4→~2/3, 3→~5/7, 2→~4/5, 1→~6/7.
- R7: A write with cfg_we=1 stores cfg_data into the pending pattern chosen by cfg_sel. The cfg_sel encoding is 0=2/3, 1=2/4, 2=3/4, 3=3/5, 4=4/5, 5=4/7, 6=5/7, 7=6/7. Only the low 4·D bits are stored, and higher data bits are dropped as zero.
- R8: The active patterns change only in a cycle with frame_sync=1. A write made mid-frame has no effect on dot_o until the next frame_sync.
- R9: On a frame_sync edge, the active copy takes the pending value from before that edge. A write in the same cycle as frame_sync therefore appears only at the following frame_sync.
- R10: cfg_restore=1 reloads all pending patterns with the defaults and wins over a write in the same cycle. Like a write, it reaches the output only at a frame_sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_grey | input | 4 | Grey level of the current pixel |
| pix_col | input | COL_W | Pixel column |
| line_idx | input | LINE_W | Line index within the frame |
| frame_idx | input | FRAME_W | Frame counter |
| frame_sync | input | 1 | Frame boundary pulse; copies pending patterns to active |
| cfg_we | input | 1 | Pattern write strobe |
| cfg_sel | input | 3 | Pattern selector for writes |
| cfg_data | input | 28 | Pattern write data |
| cfg_restore | input | 1 | Reload pending patterns with defaults |
| dot_o | output | 1 | Dithered dot value |

## Verification
The collisions of interest are a pattern write in the same cycle as the frame boundary, and a restore in the same cycle as a write. Both are provoked by directed cycles that raise the two strobes together, and random traffic also produces them at random. A bench model judges them by applying the boundary copy from the pre-edge pending value and giving the restore priority over the write. Dot values are then compared across all codes and positions in the frames before and after the next boundary.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int NUM_PAT = 8;
  localparam int ROW_W   = 4;
  localparam int MAX_ROWS = 7;
  localparam int PAT_W   = ROW_W * MAX_ROWS;
  localparam int SEL_W   = $clog2(NUM_PAT);
  localparam int NUM_DEN = 4;

  typedef logic [PAT_W-1:0] pat_t;

  // selector encoding, also used by the write port
  typedef enum logic [SEL_W-1:0] {
    PS_2OF3 = 3'd0, PS_2OF4 = 3'd1, PS_3OF4 = 3'd2, PS_3OF5 = 3'd3,
    PS_4OF5 = 3'd4, PS_4OF7 = 3'd5, PS_5OF7 = 3'd6, PS_6OF7 = 3'd7
  } pat_sel_e;

  function automatic int unsigned rows_of(int unsigned s);
    case (s)
      0:       return 3;
      1, 2:    return 4;
      3, 4:    return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int unsigned den_of_ix(int unsigned k);
    case (k)
      0:       return 3;
      1:       return 4;
      2:       return 5;
      default: return 7;
    endcase
  endfunction

  function automatic pat_t default_of(int unsigned s);
    case (s)
      0:       return 28'h00007DA;
      1:       return 28'h000A5A5;
      2:       return 28'h0007DBE;
      3:       return 28'h007A5AD;
      4:       return 28'h007DFBE;
      5:       return 28'hB9DC663;
      6:       return 28'h7B5ADEF;
      default: return 28'hFBFDFE7;
    endcase
  endfunction

  function automatic pat_t used_mask(int unsigned s);
    logic [31:0] m;
    m = (32'd1 << (ROW_W * rows_of(s))) - 32'd1;
    return m[PAT_W-1:0];
  endfunction
endpackage

// File: rtl/frc_pattern_bank.sv
module frc_pattern_bank
  import frc_pkg::*;
#(
  parameter int N_PAT = NUM_PAT,
  parameter int P_W   = PAT_W,
  parameter int S_W   = SEL_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [S_W-1:0]             wr_sel,
  input  logic [P_W-1:0]             wr_data,
  input  logic                       restore,
  input  logic                       frame_sync,
  output logic [N_PAT-1:0][P_W-1:0]  act_o
);
  logic [N_PAT-1:0][P_W-1:0] pend_q;
  logic [N_PAT-1:0][P_W-1:0] act_q;
  logic [N_PAT-1:0][P_W-1:0] def_all;

  for (genvar i = 0; i < N_PAT; i++) begin : g_slot
    localparam logic [P_W-1:0] DEF_I  = P_W'(default_of(i));
    localparam logic [P_W-1:0] MASK_I = P_W'(used_mask(i));
    logic hit;
    assign hit        = wr_en && (wr_sel == S_W'(i));
    assign def_all[i] = DEF_I;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= DEF_I;
        act_q[i]  <= DEF_I;
      end else begin
        if (frame_sync) act_q[i] <= pend_q[i];
        if (restore)    pend_q[i] <= DEF_I;
        else if (hit)   pend_q[i] <= wr_data & MASK_I;
      end
    end
  end

  assign act_o = act_q;

  AST_MIDFRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> $stable(act_q)); // R8

  AST_SYNC_TAKES_OLD: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> (act_q == $past(pend_q))); // R9

  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (rst)
    restore |=> (pend_q == def_all)); // R10
endmodule

// File: rtl/frc_row_phase.sv
module frc_row_phase
  import frc_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int FRAME_W = 8,
  parameter int N_DEN   = NUM_DEN
) (
  input  logic [LINE_W-1:0]      line_idx,
  input  logic [FRAME_W-1:0]     frame_idx,
  output logic [N_DEN-1:0][2:0]  rows_o
);
  localparam int SUM_W = ((LINE_W > FRAME_W) ? LINE_W : FRAME_W) + 1;
  logic [SUM_W-1:0] phase_sum;

  assign phase_sum = SUM_W'(line_idx) + SUM_W'(frame_idx);

  for (genvar k = 0; k < N_DEN; k++) begin : g_den
    localparam int D = den_of_ix(k);
    assign rows_o[k] = 3'(phase_sum % SUM_W'(D));
  end
endmodule

// File: rtl/frc_dot_select.sv
module frc_dot_select
  import frc_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int N_PAT = NUM_PAT,
  parameter int P_W   = PAT_W,
  parameter int N_DEN = NUM_DEN
) (
  input  logic [3:0]                 pix_grey,
  input  logic [COL_W-1:0]           pix_col,
  input  logic [N_PAT-1:0][P_W-1:0]  pat_i,
  input  logic [N_DEN-1:0][2:0]      rows_i,
  output logic                       dot_o
);
  logic [1:0]     lane;
  pat_sel_e       sel;
  logic           inv, fixed, fixed_val;
  logic [1:0]     den_ix;
  logic [2:0]     nrow, row;
  logic [4:0]     shift;
  logic [P_W-1:0] pat_cur;
  logic [3:0]     nib;

  assign lane = 2'(pix_col % COL_W'(4));

  always_comb begin
    sel = PS_2OF3; inv = 1'b0; fixed = 1'b0; fixed_val = 1'b0;
    unique case (pix_grey)
      4'd15: begin fixed = 1'b1; fixed_val = 1'b1; end
      4'd14: sel = PS_6OF7;
      4'd13: sel = PS_4OF5;
      4'd12: sel = PS_3OF4;
      4'd11: sel = PS_5OF7;
      4'd10: sel = PS_2OF3;
      4'd9:  sel = PS_3OF5;
      4'd8:  sel = PS_4OF7;
      4'd7:  sel = PS_2OF4;
      4'd6:  begin sel = PS_4OF7; inv = 1'b1; end
      4'd5:  begin sel = PS_3OF5; inv = 1'b1; end
      4'd4:  begin sel = PS_2OF3; inv = 1'b1; end
      4'd3:  begin sel = PS_5OF7; inv = 1'b1; end
      4'd2:  begin sel = PS_4OF5; inv = 1'b1; end
      4'd1:  begin sel = PS_6OF7; inv = 1'b1; end
      default: begin fixed = 1'b1; fixed_val = 1'b0; end
    endcase
  end

  always_comb begin
    unique case (sel)
      PS_2OF3:          begin den_ix = 2'd0; nrow = 3'd3; end
      PS_2OF4, PS_3OF4: begin den_ix = 2'd1; nrow = 3'd4; end
      PS_3OF5, PS_4OF5: begin den_ix = 2'd2; nrow = 3'd5; end
      default:          begin den_ix = 2'd3; nrow = 3'd7; end
    endcase
    row     = rows_i[den_ix];
    shift   = {nrow - 3'd1 - row, 2'b00};
    pat_cur = pat_i[sel];
    nib     = pat_cur[shift +: 4];
    dot_o   = fixed ? fixed_val : (nib[~lane] ^ inv);
  end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
  import frc_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int LINE_W  = 10,
  parameter int FRAME_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          pix_grey,
  input  logic [COL_W-1:0]    pix_col,
  input  logic [LINE_W-1:0]   line_idx,
  input  logic [FRAME_W-1:0]  frame_idx,
  input  logic                frame_sync,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_sel,
  input  logic [27:0]         cfg_data,
  input  logic                cfg_restore,
  output logic                dot_o
);
  logic [NUM_PAT-1:0][PAT_W-1:0] act_pats;
  logic [NUM_DEN-1:0][2:0]       rows;

  frc_pattern_bank #(.N_PAT(NUM_PAT), .P_W(PAT_W), .S_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_data), .restore(cfg_restore), .frame_sync(frame_sync),
    .act_o(act_pats)
  );

  frc_row_phase #(.LINE_W(LINE_W), .FRAME_W(FRAME_W), .N_DEN(NUM_DEN)) u_phase (
    .line_idx(line_idx), .frame_idx(frame_idx), .rows_o(rows)
  );

  frc_dot_select #(.COL_W(COL_W), .N_PAT(NUM_PAT), .P_W(PAT_W), .N_DEN(NUM_DEN)) u_sel (
    .pix_grey(pix_grey), .pix_col(pix_col), .pat_i(act_pats),
    .rows_i(rows), .dot_o(dot_o)
  );

  AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
    (pix_grey == 4'hF) |-> dot_o); // R2

  AST_FULL_OFF: assert property (@(posedge clk) disable iff (rst)
    (pix_grey == 4'h0) |-> !dot_o); // R2
endmodule

// File: tb/frc_dither_bench.sv
`timescale 1ns/1ps
module frc_dither_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  pix_grey;
  logic [9:0]  pix_col;
  logic [9:0]  line_idx;
  logic [7:0]  frame_idx;
  logic        frame_sync, cfg_we, cfg_restore;
  logic [2:0]  cfg_sel;
  logic [27:0] cfg_data;
  logic        dot_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [27:0] m_pend [8];
  logic [27:0] m_act  [8];

  always #2.5 clk = ~clk;

  frc_dither u_frc_dither (
    .clk(clk), .rst(rst), .pix_grey(pix_grey), .pix_col(pix_col),
    .line_idx(line_idx), .frame_idx(frame_idx), .frame_sync(frame_sync),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cfg_restore(cfg_restore), .dot_o(dot_o)
  );

  function automatic logic [27:0] b_def(int s);
    logic [27:0] t [8] = '{28'h00007DA, 28'h000A5A5, 28'h0007DBE, 28'h007A5AD,
                            28'h007DFBE, 28'hB9DC663, 28'h7B5ADEF, 28'hFBFDFE7};
    return t[s];
  endfunction

  function automatic int b_rows(int s);
    int t [8] = '{3, 4, 4, 5, 5, 7, 7, 7};
    return t[s];
  endfunction

  // code -> selector (R3, R6); -1 marks a fixed level
  function automatic int b_sel(int g);
    int t [16] = '{-1, 7, 4, 6, 0, 3, 5, 1, 5, 3, 0, 6, 2, 4, 7, -1};
    return t[g];
  endfunction

  function automatic logic b_dot(int g, int col, int line, int frame);
    int s, d, r;
    logic [3:0] nib;
    if (g == 15) return 1'b1;
    if (g == 0)  return 1'b0;
    s = b_sel(g);
    d = b_rows(s);
    r = (frame + line) % d;
    nib = 4'((m_act[s] >> (4 * (d - 1 - r))) & 28'hF);
    return nib[3 - (col % 4)] ^ (g < 7);
  endfunction

  task automatic probe(int g, int col, int line, int frame, string tag);
    logic e;
    pix_grey = 4'(g); pix_col = 10'(col); line_idx = 10'(line); frame_idx = 8'(frame);
    #0.1;
    e = b_dot(g, col, line, frame);
    n_vec++;
    if (dot_o !== e) begin
      n_bad++;
      $display("FAIL %s grey=%0d col=%0d line=%0d frame=%0d got=%b exp=%b",
               tag, g, col, line, frame, dot_o, e);
    end
  endtask

  task automatic rand_probe();
    int g = int'($urandom % 16);
    string tag = (g == 0 || g == 15) ? "R2" : (g < 7 ? "R6 R4 R5" : "R3 R4 R5");
    probe(g, int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 256), tag);
  endtask

  // one clock: model follows R7..R10 at the edge, returns at the negedge
  task automatic step();
    @(posedge clk);
    #1;
    if (frame_sync) for (int i = 0; i < 8; i++) m_act[i] = m_pend[i];
    if (cfg_restore) for (int i = 0; i < 8; i++) m_pend[i] = b_def(i);
    else if (cfg_we) m_pend[cfg_sel] = cfg_data & 28'((64'd1 << (4 * b_rows(int'(cfg_sel)))) - 1);
    @(negedge clk);
    frame_sync = 0; cfg_we = 0; cfg_restore = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    rst = 1; frame_sync = 0; cfg_we = 0; cfg_restore = 0; cfg_sel = 0; cfg_data = 0;
    pix_grey = 0; pix_col = 0; line_idx = 0; frame_idx = 0;
    for (int i = 0; i < 8; i++) begin m_pend[i] = b_def(i); m_act[i] = b_def(i); end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: defaults across every code and row
    for (int g = 1; g < 15; g++)
      for (int l = 0; l < 7; l++) probe(g, l * 5, l, 0, "R1");
    probe(7, 1, 0, 0, "R1");
    // R2 extremes
    probe(15, 3, 9, 4, "R2"); probe(0, 0, 0, 0, "R2");

    // R7 / R8: write with upper data bits set, no sync yet
    cfg_we = 1; cfg_sel = 3'd0; cfg_data = 28'hFFFFF00;
    step();
    probe(10, 0, 1, 0, "R8"); probe(10, 0, 0, 0, "R8");
    frame_sync = 1; step();
    probe(10, 0, 0, 0, "R7"); probe(10, 0, 1, 0, "R7"); probe(10, 2, 2, 0, "R7");
    probe(4, 0, 1, 0, "R6");

    // R9: write colliding with frame boundary
    cfg_we = 1; cfg_sel = 3'd1; cfg_data = 28'h000FFFF; frame_sync = 1;
    step();
    probe(7, 1, 0, 0, "R9"); probe(7, 0, 1, 0, "R9");
    frame_sync = 1; step();
    probe(7, 1, 0, 0, "R9"); probe(7, 0, 1, 0, "R9");

    // R10: restore colliding with a write, then seen only after sync
    cfg_restore = 1; cfg_we = 1; cfg_sel = 3'd1; cfg_data = 28'h0;
    step();
    probe(7, 1, 0, 0, "R10"); probe(10, 0, 1, 0, "R10");
    frame_sync = 1; step();
    probe(7, 0, 0, 0, "R10"); probe(7, 1, 0, 0, "R10"); probe(10, 0, 1, 0, "R10");

    // constrained random traffic
    for (int c = 0; c < 3000; c++) begin
      cfg_we      = ($urandom % 4) == 0;
      cfg_sel     = 3'($urandom % 8);
      cfg_data    = 28'($urandom);
      frame_sync  = ($urandom % 12) == 0;
      cfg_restore = ($urandom % 50) == 0;
      for (int k = 0; k < 4; k++) rand_probe();
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule